// File: doc/BRIEF.md
# Segment LCD Serial Command and Display Data Receiver

This block is the serial front end of a segment LCD controller. It listens on a two-wire I2C bus as a write-only slave. It finds START and STOP conditions, accepts one of two 7-bit slave addresses, and decodes a chain of command bytes that set the display mode, blink field, RAM word pointer and device subaddress counter. After the last command byte, every further byte is display data and goes out on a RAM write port.

Several of these controllers can share one bus address and drive one large panel. All of them follow the same commands and advance the same pointer and subaddress counter. During the data phase, a device acknowledges and stores a byte only while the subaddress counter equals its own three strap pins. The bus lines come in asynchronously and are sampled by the system clock through two-flop synchronizers. Clock stretching and read transfers are not supported.

Top module: `lcd_i2c_rx`

## Requirements
- R1: The block answers only an address byte whose upper seven bits are 0111000 with the last of those bits replaced by `sa0_i`, and whose R/W bit (bit 0) is 0. Any other address byte gets no acknowledge, and every byte after it is ignored until the next START.
- R2: After a matching address byte and after each command byte, `sda_oe_o` is 1. It asserts following the SCL falling edge that ends the eighth data bit and drops after the next SCL falling edge.
- R3: Bit 7 of a command byte is a continuation flag. When the flag is 1, another command byte follows. When it is 0, that byte is the last command and every later byte in the transfer is display data.
- R4: A command with payload bit 6 = 0 loads the RAM word pointer from payload bits 5..0, provided that value is below 40. A value of 40 or more leaves the pointer unchanged.
- R5: A command with payload bits 6..3 = 1100 loads the subaddress counter from payload bits 2..0.
- R6: A command with payload bits 6..3 = 1000 sets `bias_o` from bit 2 and `duty_o` from bits 1..0. A command with payload bits 6..2 = 11100 sets `blink_o` from bits 1..0. Every other payload changes no output.
- R7: A display byte produces a one-clock `wr_en_o` pulse, with the current pointer on `wr_addr_o` and the byte on `wr_data_o`, together with an acknowledge. This happens only when the subaddress counter equals `sub_strap_i`. Otherwise there is no write and no acknowledge.
- R8: After each display byte the pointer advances by ceil(8/n) words, where n is the number of commons given by `duty_o`: 00 means 1, 01 means 2, 10 means 3 and 11 means 4. If the result would exceed 39, the pointer becomes 0 and the subaddress counter increments modulo 8.
- R9: A STOP condition (SDA rising while SCL is high) returns the block to idle. Bytes clocked in before the next START are not acknowledged and have no effect.
- R10: A START condition (SDA falling while SCL is high) in the middle of a transfer restarts address matching. The byte after a matched address is then decoded as a command again.
- R11: After reset the outputs are: pointer 0, subaddress counter 0, `duty_o` = 11, `bias_o` = 0, `blink_o` = 00, `sda_oe_o` = 0 and `wr_en_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sa0_i | input | 1 | Strap selecting the slave address LSB |
| sub_strap_i | input | 3 | This device's subaddress straps |
| sda_oe_o | output | 1 | Pull SDA low (acknowledge) |
| bias_o | output | 1 | Bias select |
| duty_o | output | 2 | Duty code (00 static, 01 1/2, 10 1/3, 11 1/4) |
| blink_o | output | 2 | Blink field |
| wr_en_o | output | 1 | Display RAM write strobe |
| wr_addr_o | output | PTR_W | Display RAM word address |
| wr_data_o | output | 8 | Display RAM write data |

## Verification
The assertions check the following on every cycle:
- An acknowledge only ever starts right after a completed byte, and it ends only on an SCL falling edge or a bus condition.
- A write strobe needs a data byte together with a subaddress match.
- The mode outputs change only after a command byte.
- The pointer stays below 40.
- STOP and START always release SDA.

The bench scenarios are what show the rest:
- the address and R/W filtering;
- the decoding of each command code, including ignored codes and out-of-range pointer loads;
- the pointer step for every duty mode, the wrap past word 39 with the subaddress counter rolling from 7 to 0;
- the return to command decoding after a repeated START.

// File: rtl/lcdrx_pkg.sv
package lcdrx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_CMD,
    PH_DATA,
    PH_SKIP
  } phase_e;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_PTR,
    OP_SUB,
    OP_MODE,
    OP_BLINK
  } op_e;

  // Address byte accepted: upper bits match, LSB strap, write direction.
  function automatic logic addr_hit(input logic [7:0] b, input logic [5:0] hi,
                                    input logic sa0);
    return (b[7:1] == {hi, sa0}) && !b[0];
  endfunction

  // Classify a 7-bit command payload.
  function automatic op_e op_of(input logic [6:0] p);
    if (!p[6])                  return OP_PTR;
    else if (p[5:3] == 3'b100)  return OP_SUB;
    else if (p[5:3] == 3'b000)  return OP_MODE;
    else if (p[5:2] == 4'b1100) return OP_BLINK;
    else                        return OP_NONE;
  endfunction

  // RAM words filled by one display byte: ceil(8 / commons).
  function automatic logic [3:0] words_per_byte(input logic [1:0] duty);
    case (duty)
      2'b00:   return 4'd8;
      2'b01:   return 4'd4;
      2'b10:   return 4'd3;
      default: return 4'd2;
    endcase
  endfunction

endpackage

// File: rtl/lcdrx_sync.sv
module lcdrx_sync #(
  parameter int LINES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] pin_i,
  output logic [LINES-1:0] lvl_o,
  output logic [LINES-1:0] prev_o
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [2:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= 3'b111;
      else        pipe <= {pipe[1:0], pin_i[g]};
    end
    assign lvl_o[g]  = pipe[1];
    assign prev_o[g] = pipe[2];
  end

endmodule

// File: rtl/lcdrx_link.sv
module lcdrx_link
  import lcdrx_pkg::*;
#(
  parameter logic [5:0] ADDR_HI = 6'b011100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic       sda_lvl,
  input  logic       sa0,
  input  logic       sel,
  output logic       byte_done,
  output logic [7:0] byte_val,
  output phase_e     phase_o,
  output logic       ack_o
);

  logic [7:0] shreg;
  logic [3:0] nbits;
  logic       in_ack;
  phase_e     phase;
  phase_e     phase_nxt;
  logic       want;

  assign byte_done = scl_fall && !in_ack && (nbits == 4'd8) && (phase != PH_IDLE);
  assign byte_val  = shreg;
  assign phase_o   = phase;

  always_comb begin
    want      = 1'b0;
    phase_nxt = phase;
    unique case (phase)
      PH_ADDR: begin
        want      = addr_hit(shreg, ADDR_HI, sa0);
        phase_nxt = want ? PH_CMD : PH_SKIP;
      end
      PH_CMD: begin
        want      = 1'b1;
        phase_nxt = shreg[7] ? PH_CMD : PH_DATA;
      end
      PH_DATA: want = sel;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      nbits  <= '0;
      in_ack <= 1'b0;
      ack_o  <= 1'b0;
      phase  <= PH_IDLE;
    end else if (start_ev) begin
      nbits  <= '0;
      in_ack <= 1'b0;
      ack_o  <= 1'b0;
      phase  <= PH_ADDR;
    end else if (stop_ev) begin
      nbits  <= '0;
      in_ack <= 1'b0;
      ack_o  <= 1'b0;
      phase  <= PH_IDLE;
    end else begin
      if (scl_rise && !in_ack && phase != PH_IDLE && nbits != 4'd8) begin
        shreg <= {shreg[6:0], sda_lvl};
        nbits <= nbits + 4'd1;
      end
      if (byte_done) begin
        in_ack <= 1'b1;
        nbits  <= '0;
        ack_o  <= want;
        phase  <= phase_nxt;
      end else if (scl_fall && in_ack) begin
        in_ack <= 1'b0;
        ack_o  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/lcdrx_regs.sv
module lcdrx_regs
  import lcdrx_pkg::*;
#(
  parameter int SEG_WORDS = 40,
  parameter int SUB_W     = 3,
  localparam int PTR_W    = $clog2(SEG_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_done,
  input  logic             data_done,
  input  logic [7:0]       byte_val,
  input  logic [SUB_W-1:0] sub_strap,
  output logic             sel_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic             bias_o,
  output logic [1:0]       duty_o,
  output logic [1:0]       blink_o,
  output logic             wr_en_o,
  output logic [PTR_W-1:0] wr_addr_o,
  output logic [7:0]       wr_data_o
);

  localparam logic [PTR_W:0] WORDS_V = (PTR_W+1)'(SEG_WORDS);

  logic [PTR_W-1:0] ptr;
  logic [SUB_W-1:0] sub;
  logic [PTR_W:0]   ptr_sum;
  logic             load_fits;

  assign ptr_sum   = {1'b0, ptr} + (PTR_W+1)'(words_per_byte(duty_o));
  assign load_fits = {2'b00, byte_val[5:0]} < 8'(SEG_WORDS);
  assign sel_o     = (sub == sub_strap);
  assign ptr_o     = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr       <= '0;
      sub       <= '0;
      bias_o    <= 1'b0;
      duty_o    <= 2'b11;
      blink_o   <= 2'b00;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (cmd_done) begin
        unique case (op_of(byte_val[6:0]))
          OP_PTR:   if (load_fits) ptr <= PTR_W'(byte_val[5:0]);
          OP_SUB:   sub <= SUB_W'(byte_val[2:0]);
          OP_MODE: begin
            bias_o <= byte_val[2];
            duty_o <= byte_val[1:0];
          end
          OP_BLINK: blink_o <= byte_val[1:0];
          default: ;
        endcase
      end
      if (data_done) begin
        wr_en_o <= sel_o;
        if (sel_o) begin
          wr_addr_o <= ptr;
          wr_data_o <= byte_val;
        end
        if (ptr_sum >= WORDS_V) begin
          ptr <= '0;
          sub <= sub + 1'b1;
        end else begin
          ptr <= ptr_sum[PTR_W-1:0];
        end
      end
    end
  end

endmodule

// File: rtl/lcd_i2c_rx.sv
module lcd_i2c_rx
  import lcdrx_pkg::*;
#(
  parameter int         SEG_WORDS = 40,
  parameter logic [5:0] ADDR_HI   = 6'b011100,
  localparam int        PTR_W     = $clog2(SEG_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             sa0_i,
  input  logic [2:0]       sub_strap_i,
  output logic             sda_oe_o,
  output logic             bias_o,
  output logic [1:0]       duty_o,
  output logic [1:0]       blink_o,
  output logic             wr_en_o,
  output logic [PTR_W-1:0] wr_addr_o,
  output logic [7:0]       wr_data_o
);

  logic [1:0] lvl, prev;
  logic       scl_rise_w, scl_fall_w, start_w, stop_w;
  logic       byte_done_w, cmd_done_w, data_done_w, sel_w;
  logic [7:0] byte_w;
  logic [PTR_W-1:0] ptr_w;
  phase_e     phase_w;

  // line 0 = SCL, line 1 = SDA
  lcdrx_sync #(.LINES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i({sda_i, scl_i}), .lvl_o(lvl), .prev_o(prev)
  );

  assign scl_rise_w = lvl[0] && !prev[0];
  assign scl_fall_w = !lvl[0] && prev[0];
  assign start_w    = lvl[0] && prev[0] && prev[1] && !lvl[1];
  assign stop_w     = lvl[0] && prev[0] && !prev[1] && lvl[1];

  lcdrx_link #(.ADDR_HI(ADDR_HI)) u_link (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise_w), .scl_fall(scl_fall_w),
    .start_ev(start_w), .stop_ev(stop_w), .sda_lvl(lvl[1]), .sa0(sa0_i),
    .sel(sel_w), .byte_done(byte_done_w), .byte_val(byte_w), .phase_o(phase_w),
    .ack_o(sda_oe_o)
  );

  assign cmd_done_w  = byte_done_w && (phase_w == PH_CMD);
  assign data_done_w = byte_done_w && (phase_w == PH_DATA);

  lcdrx_regs #(.SEG_WORDS(SEG_WORDS), .SUB_W(3)) u_regs (
    .clk(clk), .rst_n(rst_n), .cmd_done(cmd_done_w), .data_done(data_done_w),
    .byte_val(byte_w), .sub_strap(sub_strap_i), .sel_o(sel_w), .ptr_o(ptr_w),
    .bias_o(bias_o), .duty_o(duty_o), .blink_o(blink_o), .wr_en_o(wr_en_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
  );

endmodule

// File: rtl/lcd_i2c_rx_chk.sv
module lcd_i2c_rx_chk #(
  parameter int SEG_WORDS = 40,
  parameter int PTR_W     = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sda_oe_o,
  input logic             wr_en_o,
  input logic             bias_o,
  input logic [1:0]       duty_o,
  input logic [1:0]       blink_o,
  input logic             scl_fall_w,
  input logic             start_w,
  input logic             stop_w,
  input logic             byte_done_w,
  input logic             cmd_done_w,
  input logic             data_done_w,
  input logic             sel_w,
  input logic [PTR_W-1:0] ptr_w
);

  a_r2_ack_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> $past(byte_done_w));

  a_r2_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe_o) |-> $past(scl_fall_w || start_w || stop_w));

  a_r7_write_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> $past(data_done_w && sel_w));

  a_r7_write_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> !wr_en_o);

  a_r6_mode_by_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({bias_o, duty_o, blink_o}) |-> $past(cmd_done_w));

  a_r8_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr_w) < SEG_WORDS);

  a_r9_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_w |=> !sda_oe_o);

  a_r10_start_release: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |=> !sda_oe_o);

endmodule

bind lcd_i2c_rx lcd_i2c_rx_chk #(.SEG_WORDS(SEG_WORDS), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe_o(sda_oe_o), .wr_en_o(wr_en_o),
  .bias_o(bias_o), .duty_o(duty_o), .blink_o(blink_o),
  .scl_fall_w(scl_fall_w), .start_w(start_w), .stop_w(stop_w),
  .byte_done_w(byte_done_w), .cmd_done_w(cmd_done_w), .data_done_w(data_done_w),
  .sel_w(sel_w), .ptr_w(ptr_w)
);

// File: tb/test_lcd_i2c_rx.sv
module test_lcd_i2c_rx;
  localparam int H = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       scl_drv = 1'b1;
  logic       sda_drv = 1'b1;
  logic       sa0 = 1'b1;
  logic [2:0] strap = 3'd2;
  logic       sda_oe, bias, wr_en;
  logic [1:0] duty, blink;
  logic [5:0] wr_addr;
  logic [7:0] wr_data;
  logic       sda_bus;
  assign sda_bus = sda_drv & ~sda_oe;

  lcd_i2c_rx i_lcd_i2c_rx (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_bus), .sa0_i(sa0),
    .sub_strap_i(strap), .sda_oe_o(sda_oe), .bias_o(bias), .duty_o(duty),
    .blink_o(blink), .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  int checks = 0;
  int errors = 0;
  // reference model state: phase 0 idle, 1 address, 2 command, 3 data, 4 skip
  int m_phase = 0, m_ptr = 0, m_sub = 0, m_duty = 3, m_bias = 0, m_blink = 0;
  logic [13:0] exp_q[$];
  int hi_cnt = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_byte(input int v, output int ack);
    int p;
    int c;
    ack = 0;
    p = v % 128;
    case (m_phase)
      1: if ((v / 2) == (56 + sa0) && (v % 2) == 0) begin ack = 1; m_phase = 2; end
         else m_phase = 4;
      2: begin
        ack = 1;
        if (p < 64) begin if (p < 40) m_ptr = p; end
        else if (p / 8 == 12) m_sub = p % 8;
        else if (p / 8 == 8) begin m_bias = (p / 4) % 2; m_duty = p % 4; end
        else if (p / 4 == 28) m_blink = p % 4;
        if (v < 128) m_phase = 3;
      end
      3: begin
        c = m_duty + 1;
        if (m_sub == int'(strap)) begin
          ack = 1;
          exp_q.push_back({6'(m_ptr), 8'(v)});
        end
        m_ptr = m_ptr + (8 + c - 1) / c;
        if (m_ptr > 39) begin m_ptr = 0; m_sub = (m_sub + 1) % 8; end
      end
      default: ;
    endcase
  endtask

  task automatic bus_start();
    if (!scl_drv) begin
      sda_drv = 1'b1; tick(H/2);
      scl_drv = 1'b1; tick(H/2);
    end else tick(H);
    sda_drv = 1'b0;
    m_phase = 1;
    tick(H/2);
    scl_drv = 1'b0; tick(H/2);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; tick(H/2);
    scl_drv = 1'b1; tick(H/2);
    sda_drv = 1'b1;
    m_phase = 0;
    tick(H);
  endtask

  task automatic send_byte(input logic [7:0] v, input string req);
    int ack;
    ack = 0;
    for (int i = 7; i >= 0; i--) begin
      sda_drv = v[i]; tick(H/2);
      scl_drv = 1'b1; tick(H);
      scl_drv = 1'b0; tick(1);
      if (i == 0) model_byte(int'(v), ack);
      tick(H/2 - 1);
    end
    sda_drv = 1'b1; tick(H/2);
    scl_drv = 1'b1; tick(H/2);
    chk(sda_oe == ack[0], {req, " ack"}, int'(sda_oe), ack);
    tick(H/2);
    scl_drv = 1'b0; tick(H/2);
    chk(sda_oe == 1'b0, "R2 ack released", int'(sda_oe), 0);
  endtask

  // R6 / R11: mode outputs compared with the model while SCL is steady high
  always @(posedge clk) hi_cnt <= scl_drv ? hi_cnt + 1 : 0;
  always @(negedge clk)
    if (rst_n && hi_cnt >= 6)
      chk(bias == m_bias[0] && int'(duty) == m_duty && int'(blink) == m_blink,
          "R6 mode outputs", int'({bias, duty, blink}), m_bias * 16 + m_duty * 4 + m_blink);

  // R7 / R8: every write strobe matches the next expected write
  always @(negedge clk)
    if (rst_n && wr_en) begin
      if (exp_q.size() == 0) chk(1'b0, "R7 unexpected write", int'(wr_addr), -1);
      else begin
        logic [13:0] e;
        e = exp_q.pop_front();
        chk({wr_addr, wr_data} == e, "R7 R8 write address/data",
            int'({wr_addr, wr_data}), int'(e));
      end
    end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(5);
    chk(sda_oe == 1'b0 && wr_en == 1'b0, "R11 reset outputs", int'({sda_oe, wr_en}), 0);
    chk(duty == 2'b11 && bias == 1'b0 && blink == 2'b00, "R11 reset mode",
        int'({bias, duty, blink}), 12);
    rst_n = 1'b1;
    tick(10);

    // R1: other SA0 level, then R/W = 1
    bus_start(); send_byte(8'h70, "R1 wrong lsb"); send_byte(8'hC1, "R1 ignored cmd"); bus_stop();
    bus_start(); send_byte(8'h73, "R1 read dir"); bus_stop();

    // R3 R4 R5 R6 R7 R8: chain, write at 36 then wrap into sub 3
    bus_start(); send_byte(8'h72, "R1 match");
    send_byte(8'hE2, "R5 sub load"); send_byte(8'hC1, "R6 mode 1/2");
    send_byte(8'hF2, "R6 blink"); send_byte(8'h24, "R4 ptr last R3");
    send_byte(8'hA5, "R7 data at 36"); send_byte(8'h5C, "R8 wrapped no ack");
    bus_stop();

    // R4 R6: ignored code, out-of-range pointer
    bus_start(); send_byte(8'h72, "R1 match");
    send_byte(8'h85, "R4 ptr 5"); send_byte(8'hFF, "R6 ignored code");
    send_byte(8'hB0, "R4 ptr 48 ignored"); send_byte(8'h62, "R5 sub 2 last");
    send_byte(8'h3C, "R7 data at 5"); bus_stop();

    // R8: static duty, counter wraps 7 -> 0 -> 1 -> 2
    bus_start(); send_byte(8'h72, "R1 match");
    send_byte(8'hE7, "R5 sub 7"); send_byte(8'hC0, "R6 static");
    send_byte(8'h20, "R4 ptr 32 R3");
    for (int k = 0; k < 17; k++) send_byte(8'(8'h10 + k), "R8 static stream");
    bus_stop();

    // R8: 1/3 duty, boundary at word 39
    bus_start(); send_byte(8'h72, "R1 match");
    send_byte(8'hC6, "R6 bias 1 1/3"); send_byte(8'hE2, "R5 sub 2");
    send_byte(8'h21, "R4 ptr 33");
    for (int k = 0; k < 4; k++) send_byte(8'(8'h90 + k), "R8 third duty");
    bus_stop();

    // R9: byte after STOP without START
    send_byte(8'hC0, "R9 after stop");

    // R10: repeated START returns to command decoding
    bus_start(); send_byte(8'h72, "R1 match");
    send_byte(8'hE2, "R5 sub 2"); send_byte(8'h00, "R4 ptr 0");
    send_byte(8'h5A, "R7 data before restart");
    bus_start(); send_byte(8'h72, "R10 readdress");
    send_byte(8'h43, "R10 cmd after restart"); send_byte(8'h33, "R10 data");
    bus_stop();

    tick(20);
    chk(exp_q.size() == 0, "R7 all writes seen", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule